// File: doc/BRIEF.md
# Oversampled start-stop word receiver

This block receives 16-bit words sent over a single data wire with no separate strobe. A local clock runs at sixteen times the bit rate. Each word travels as a frame: a low start bit, the sixteen data bits with the most significant bit first, and a high stop bit. Between frames the line rests high.

The receiver first passes the line through a two-flop synchroniser. It then waits for a falling edge and counts clocks from that edge so that each bit cell is sampled at its centre. A start bit that is no longer low at its centre is treated as noise and dropped without any report. When the stop bit reads high, the assembled word is written to the output register and a one-clock load strobe is raised. When the stop bit reads low, a one-clock error pulse is raised instead, the output register is left untouched, and the receiver waits for the line to go high again before it looks for the next start edge.

Top module: `async_word_rx`

## Requirements
- R1: After reset, word_o is 0x0000 and load_o and frame_err_o are both 0.
- R2: A frame is one start bit (0), then 16 data bits with bit 15 first and bit 0 last, then one stop bit (1), each bit held for 16 clocks; on a valid frame word_o bit 15 equals the first data bit received.
- R3: Counting from the first clock after the synchronised line falls, the start bit is checked at clock 8, bit 15 is sampled at clock 24, each following bit 16 clocks later, and the stop bit at clock 280, so alternating bit patterns sent back to back are received without slip.
- R4: When the stop bit reads 1, word_o takes the received word and load_o is 1 for exactly one clock, in the same cycle word_o changes.
- R5: When the stop bit reads 0, frame_err_o is 1 for exactly one clock in the cycle after the stop sample, load_o stays 0 and word_o keeps its previous value.
- R6: A low pulse on the line that has returned to 1 by the start-bit centre produces neither load_o nor frame_err_o and leaves word_o unchanged.
- R7: After a framing error, the receiver ignores the line until it has been seen high, and then accepts the next frame normally.
- R8: A new start bit that follows the stop bit directly, with no idle cells, is received as a valid frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock, 16 times the bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Serial data line, idle high |
| word_o | output | 16 | Last word received with a valid stop bit |
| load_o | output | 1 | One-clock strobe when word_o is updated |
| frame_err_o | output | 1 | One-clock pulse after a stop bit read as 0 |

## Verification
The bench sends words with alternating bits (0xAAAA, 0x5555), with all ones and all zeros, and with distinct high and low bytes, so that a slip of one cell or a reversed bit order shows up as a wrong word. Frames sent back to back with no idle gap test that the stop-cell sample and re-arming leave room for an immediate start edge. A frame with a low stop bit, followed by a line held low and then released, separates a correct framing check and re-arm from a design that loads anyway or re-arms too early. A short low glitch, followed by a good frame, shows that a false start is dropped silently.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_HOLD = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;  // line idles high
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int OVS    = 16,
  parameter int DATA_W = 16,
  localparam int PH_W  = $clog2(OVS),
  localparam int IDX_W = $clog2(DATA_W + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  output logic             tick_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0]  PH_MID  = PH_W'(OVS / 2);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DATA_W + 1);

  logic [PH_W-1:0]  phase_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      idx_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_W'(1);  // clock 1 of the start cell
      idx_q   <= '0;
    end else if (run_i) begin
      if (phase_q == PH_LAST) begin
        phase_q <= '0;
        idx_q   <= idx_q + IDX_W'(1);
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end

  assign tick_o = run_i && (phase_q == PH_MID);
  assign idx_o  = idx_q;

  // FSM must leave the receive state at the stop sample
  p_idx_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (idx_q <= IDX_MAX));
endmodule

// File: rtl/rx_shift.sv
module rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[DATA_W-2:0], bit_i};  // MSB arrives first
  end

  assign data_o = sr_q;
endmodule

// File: rtl/async_word_rx.sv
module async_word_rx
  import async_rx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic [DATA_W-1:0] word_o,
  output logic              load_o,
  output logic              frame_err_o
);
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [IDX_W-1:0] IDX_START = '0;
  localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] IDX_STOP  = IDX_W'(DATA_W + 1);

  rx_state_e         state_q;
  logic              line_s, line_q;
  logic              fall, start, run, tick, shift;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sr_data;
  logic [DATA_W-1:0] word_q;
  logic              load_q, err_q;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b1;
    else         line_q <= line_s;
  end

  assign fall  = line_q && !line_s;
  assign start = (state_q == ST_IDLE) && fall;
  assign run   = (state_q == ST_RECV);
  assign shift = tick && (idx >= IDX_FIRST) && (idx <= IDX_LAST);

  rx_bit_timer #(.OVS(OVS), .DATA_W(DATA_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .run_i  (run),
    .tick_o (tick),
    .idx_o  (idx)
  );

  rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift),
    .bit_i  (line_s),
    .data_o (sr_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      load_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      load_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fall) state_q <= ST_RECV;
        ST_RECV: begin
          if (tick && idx == IDX_START && line_s) begin
            state_q <= ST_IDLE;  // false start, drop silently
          end else if (tick && idx == IDX_STOP) begin
            if (line_s) begin
              word_q  <= sr_data;
              load_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              err_q   <= 1'b1;
              state_q <= ST_HOLD;
            end
          end
        end
        ST_HOLD: if (line_s) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign word_o      = word_q;
  assign load_o      = load_q;
  assign frame_err_o = err_q;

  p_load_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  p_err_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);

  p_err_no_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_o && frame_err_o));

  p_word_only_on_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> load_o);

  p_err_then_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> (state_q == ST_HOLD || line_s));

  p_glitch_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick && idx == IDX_START && line_s) |=> (!load_o && !frame_err_o));
endmodule

// File: tb/sim_async_word_rx.sv
module sim_async_word_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line = 1'b1;
  logic [15:0] word;
  logic        load, ferr;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  logic        exp_err[$];
  logic [15:0] exp_word[$];
  logic [15:0] last_good = 16'h0000;
  logic        prev_load = 1'b0, prev_err = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  async_word_rx u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_i     (line),
    .word_o     (word),
    .load_o     (load),
    .frame_err_o(ferr)
  );

  task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    line = v;
    repeat (n) @(negedge clk);
  endtask

  // drive one frame, push the expected outcome, then leave line at after_lvl
  task automatic send(input logic [15:0] d, input logic stop_b, input logic after_lvl, input int after_n);
    if (stop_b) begin
      exp_err.push_back(1'b0); exp_word.push_back(d); last_good = d;
    end else begin
      exp_err.push_back(1'b1); exp_word.push_back(last_good);
    end
    hold(1'b0, 16);
    for (int i = 15; i >= 0; i--) hold(d[i], 16);
    hold(stop_b, 16);
    hold(after_lvl, after_n);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_load && load) check("R4 load width", 1'b0, 32'(load), 32'd0);
      if (prev_err && ferr)  check("R5 error width", 1'b0, 32'(ferr), 32'd0);
      if (load || ferr) begin
        if (exp_err.size() == 0) begin
          check("R6 unexpected output", 1'b0, {15'd0, ferr, word}, 32'd0);
        end else begin
          logic        e;
          logic [15:0] w;
          e = exp_err.pop_front();
          w = exp_word.pop_front();
          check(e ? "R5 error kind" : "R4 load kind", (ferr == e) && (load == !e),
                32'({load, ferr}), 32'({!e, e}));
          check(e ? "R5 word kept" : "R2 R3 word", word == w, 32'(word), 32'(w));
        end
      end
      prev_load <= load;
      prev_err  <= ferr;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check("watchdog", 1'b0, 32'(cycles), 32'd150000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 word", word == 16'h0000, 32'(word), 32'd0);
    check("R1 strobes", !load && !ferr, 32'({load, ferr}), 32'd0);
    rst_n = 1'b1;
    hold(1'b1, 10);

    // R2 R3 distinct patterns
    send(16'hA5C3, 1'b1, 1'b1, 20);
    send(16'hFFFF, 1'b1, 1'b1, 20);
    send(16'h0000, 1'b1, 1'b1, 20);
    // R8 back to back, alternating bits expose slip (R3)
    send(16'hAAAA, 1'b1, 1'b1, 0);
    send(16'h5555, 1'b1, 1'b1, 0);
    send(16'h8001, 1'b1, 1'b1, 20);

    // R6 short glitch: low for 4 clocks only
    hold(1'b0, 4);
    hold(1'b1, 40);
    check("R6 word after glitch", word == 16'h8001, 32'(word), 32'h8001);
    send(16'h1234, 1'b1, 1'b1, 20);

    // R5 bad stop, then R7 line held low before release
    send(16'h0F0F, 1'b0, 1'b0, 50);
    check("R5 word unchanged", word == 16'h1234, 32'(word), 32'h1234);
    hold(1'b1, 24);
    send(16'hC0DE, 1'b1, 1'b1, 20);

    // R5 bad stop released straight to idle, then R7 recovery
    send(16'hFFFE, 1'b0, 1'b1, 20);
    send(16'h7E81, 1'b1, 1'b1, 30);

    check("R7 final word", word == 16'h7E81, 32'(word), 32'h7E81);
    check("R4 all results seen", exp_err.size() == 0, 32'(exp_err.size()), 32'd0);
    finish_run();
  end
endmodule